// File: doc/BRIEF.md
# Always-on wakeup and watchdog timer

This block holds two independent timers behind a small 32-bit register port. The wakeup timer is a 64-bit up-counter stepped through a 12-bit prescaler. When its count reaches or passes a 64-bit compare value it raises a wakeup interrupt and a wakeup request towards the power controller, and it records the cause in a reason flag. Software reaches both 64-bit quantities as a low word and a high word.

The watchdog is a 32-bit counter that steps on every clock while enabled. It can be told to hold still while the system sleeps. Past a warning threshold it latches a bark, which drives both a maskable interrupt and a non-maskable interrupt line. Past a kill threshold it raises a reset request until software clears the count or turns the watchdog off. A lock bit, which can only be cleared, freezes the watchdog configuration and thresholds. A separate register drives a plain alert level for test purposes.

The register port is single-cycle. A write takes effect at the next rising clock edge. Read data is a combinational function of the address.

Top module: `wwt_top`

## Requirements
- R1: After reset, both counters and the prescaler phase are 0, all four threshold words read 0xFFFFFFFF, the lock bit at 0x18 reads 1, the interrupt status, reason flag and alert are 0, and every output is low.
- R2: Writable registers read back what was written, and unused bits read 0. The registers are: wake config 0x00 (bit 0 enable, bits 12:1 prescale), wake count low/high 0x04/0x08, wake compare low/high 0x0C/0x10, watchdog config 0x14 (bit 0 enable, bit 1 hold in sleep), watchdog count 0x1C, warning threshold 0x20, kill threshold 0x24.
- R3: While enabled, the wake count advances by one every prescale+1 clocks. The prescale phase restarts from 0 whenever the timer is disabled.
- R4: The 64-bit count and compare value are compared at full width. In the cycle after the enabled count is greater than or equal to the compare value, status bit 0 (0x28) is set, irq_wake_o and wake_req_o go high, and the reason flag (0x30 bit 0) is set. Writing 0 to 0x30 bit 0 clears that flag.
- R5: With the wake timer disabled the count holds its value. A write to any count or compare word takes part in the comparison from the next cycle.
- R6: The watchdog count advances by one per clock while enabled and saturates at all ones. When the hold-in-sleep bit and sleep_i are both high, it holds. With the hold-in-sleep bit clear, sleep_i has no effect.
- R7: In the cycle after the enabled watchdog count is at or above the warning threshold, status bit 1 is set, and it drives both irq_bark_o and nmi_bark_o.
- R8: In the cycle after the enabled watchdog count is at or above the kill threshold, bite_req_o goes high. It drops the cycle after the count is rewritten below the threshold or the watchdog is disabled.
- R9: Writing 0 to bit 0 of 0x18 clears the lock bit. While it is clear, writes to 0x14, 0x20 and 0x24 are ignored, and writing 1 to 0x18 does not set the bit again.
- R10: Writing 1 to bits of 0x28 clears those status bits. Writing 1 to bits of 0x2C sets them. A hardware event in the same cycle wins over a clear.
- R11: alert_o follows bit 0 of the last value written to 0x34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | System is asleep |
| bus_en_i | input | 1 | Register access valid |
| bus_we_i | input | 1 | Access is a write |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for bus_addr_i |
| irq_wake_o | output | 1 | Wakeup interrupt |
| irq_bark_o | output | 1 | Watchdog warning interrupt |
| nmi_bark_o | output | 1 | Watchdog warning non-maskable interrupt |
| wake_req_o | output | 1 | Wakeup request to the power controller |
| bite_req_o | output | 1 | Reset request from the watchdog |
| alert_o | output | 1 | Test alert level |

## Verification
The assertions treat a write as an access whose enable and write flags are both high in one cycle, and they decode the address only then. The hold, freeze and stickiness properties are therefore exempt in any cycle where such a write targets the register in question. sleep_i may change in any cycle, and the properties condition on its sampled value instead of assuming it is stable. The stimulus drives every access for exactly one clock, changes inputs only on the falling edge, and never issues a read and a write in the same cycle.

// File: rtl/wwt_pkg.sv
package wwt_pkg;
    // Byte offsets of the register map
    localparam int unsigned OFS_WAKE_CFG    = 'h00;
    localparam int unsigned OFS_WAKE_CNT_LO = 'h04;
    localparam int unsigned OFS_WAKE_CNT_HI = 'h08;
    localparam int unsigned OFS_WAKE_CMP_LO = 'h0C;
    localparam int unsigned OFS_WAKE_CMP_HI = 'h10;
    localparam int unsigned OFS_DOG_CFG     = 'h14;
    localparam int unsigned OFS_DOG_LOCK    = 'h18;
    localparam int unsigned OFS_DOG_CNT     = 'h1C;
    localparam int unsigned OFS_DOG_WARN    = 'h20;
    localparam int unsigned OFS_DOG_KILL    = 'h24;
    localparam int unsigned OFS_IRQ_STATUS  = 'h28;
    localparam int unsigned OFS_IRQ_FORCE   = 'h2C;
    localparam int unsigned OFS_WAKE_REASON = 'h30;
    localparam int unsigned OFS_ALERT_FORCE = 'h34;

    // Field positions
    localparam int unsigned WAKE_EN_BIT   = 0;
    localparam int unsigned PRESC_LSB     = 1;
    localparam int unsigned DOG_EN_BIT    = 0;
    localparam int unsigned DOG_HOLD_BIT  = 1;
    localparam int unsigned IRQ_WAKE_BIT  = 0;
    localparam int unsigned IRQ_BARK_BIT  = 1;
    localparam int unsigned IRQ_BITS      = 2;
endpackage

// File: rtl/wwt_wake_counter.sv
module wwt_wake_counter #(
    parameter int unsigned HALF_W = 32,
    parameter int unsigned PRE_W  = 12
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                en_i,
    input  logic [PRE_W-1:0]    presc_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [HALF_W-1:0]   wdata_i,
    input  logic [2*HALF_W-1:0] cmp_i,
    output logic [2*HALF_W-1:0] cnt_o,
    output logic                hit_o
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } wake_st_t;

    wake_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            if (st_q.pre == presc_i) begin
                st_d.pre = '0;
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end else begin
            st_d.pre = '0;
        end
        if (wr_lo_i) st_d.cnt[HALF_W-1:0]     = wdata_i;
        if (wr_hi_i) st_d.cnt[CNT_W-1:HALF_W] = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign hit_o = (st_q.cnt >= cmp_i);
endmodule

// File: rtl/wwt_dog_counter.sv
module wwt_dog_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         hold_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] warn_i,
    input  logic [W-1:0] kill_i,
    output logic [W-1:0] cnt_o,
    output logic         warn_hit_o,
    output logic         kill_hit_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_i) begin
            cnt_d = wdata_i;
        end else if (en_i && !hold_i && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o      = cnt_q;
    assign warn_hit_o = en_i && (cnt_q >= warn_i);
    assign kill_hit_o = en_i && (cnt_q >= kill_i);
endmodule

// File: rtl/wwt_top.sv
module wwt_top
    import wwt_pkg::*;
#(
    parameter int unsigned DW     = 32,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned PRE_W  = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sleep_i,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              irq_wake_o,
    output logic              irq_bark_o,
    output logic              nmi_bark_o,
    output logic              wake_req_o,
    output logic              bite_req_o,
    output logic              alert_o
);
    localparam int unsigned WAKE_W = 2 * DW;
    localparam int unsigned DOG_W  = DW;
    localparam int unsigned CFG_PAD = DW - PRE_W - 1;

    typedef struct packed {
        logic                wake_en;
        logic [PRE_W-1:0]    presc;
        logic [WAKE_W-1:0]   wake_cmp;
        logic                dog_en;
        logic                dog_hold;
        logic                dog_lock;
        logic [DOG_W-1:0]    warn;
        logic [DOG_W-1:0]    kill;
        logic [IRQ_BITS-1:0] intr;
        logic                reason;
        logic                alert;
        logic                bite;
    } ctl_t;

    ctl_t q, d;

    logic                wr;
    logic                wake_wr_lo, wake_wr_hi, dog_wr;
    logic [WAKE_W-1:0]   wake_cnt;
    logic [DOG_W-1:0]    dog_cnt;
    logic                wake_hit, warn_hit, kill_hit, wake_evt;
    logic [IRQ_BITS-1:0] intr_clr, intr_frc, intr_hw;

    assign wr         = bus_en_i && bus_we_i;
    assign wake_wr_lo = wr && (bus_addr_i == ADDR_W'(OFS_WAKE_CNT_LO));
    assign wake_wr_hi = wr && (bus_addr_i == ADDR_W'(OFS_WAKE_CNT_HI));
    assign dog_wr     = wr && (bus_addr_i == ADDR_W'(OFS_DOG_CNT));

    wwt_wake_counter #(.HALF_W(DW), .PRE_W(PRE_W)) u_wake (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (q.wake_en),
        .presc_i (q.presc),
        .wr_lo_i (wake_wr_lo),
        .wr_hi_i (wake_wr_hi),
        .wdata_i (bus_wdata_i),
        .cmp_i   (q.wake_cmp),
        .cnt_o   (wake_cnt),
        .hit_o   (wake_hit)
    );

    wwt_dog_counter #(.W(DOG_W)) u_dog (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (q.dog_en),
        .hold_i     (q.dog_hold && sleep_i),
        .wr_i       (dog_wr),
        .wdata_i    (bus_wdata_i),
        .warn_i     (q.warn),
        .kill_i     (q.kill),
        .cnt_o      (dog_cnt),
        .warn_hit_o (warn_hit),
        .kill_hit_o (kill_hit)
    );

    assign wake_evt = q.wake_en && wake_hit;

    always_comb begin
        intr_hw = '0;
        intr_hw[IRQ_WAKE_BIT] = wake_evt;
        intr_hw[IRQ_BARK_BIT] = warn_hit;
    end

    // Next-state computation for the control registers
    always_comb begin
        d        = q;
        intr_clr = '0;
        intr_frc = '0;
        if (wr) begin
            case (bus_addr_i)
                ADDR_W'(OFS_WAKE_CFG): begin
                    d.wake_en = bus_wdata_i[WAKE_EN_BIT];
                    d.presc   = bus_wdata_i[PRESC_LSB +: PRE_W];
                end
                ADDR_W'(OFS_WAKE_CMP_LO): d.wake_cmp[DW-1:0]      = bus_wdata_i;
                ADDR_W'(OFS_WAKE_CMP_HI): d.wake_cmp[WAKE_W-1:DW] = bus_wdata_i;
                ADDR_W'(OFS_DOG_CFG): begin
                    if (q.dog_lock) begin
                        d.dog_en   = bus_wdata_i[DOG_EN_BIT];
                        d.dog_hold = bus_wdata_i[DOG_HOLD_BIT];
                    end
                end
                ADDR_W'(OFS_DOG_LOCK): begin
                    if (!bus_wdata_i[0]) d.dog_lock = 1'b0;
                end
                ADDR_W'(OFS_DOG_WARN): begin
                    if (q.dog_lock) d.warn = bus_wdata_i;
                end
                ADDR_W'(OFS_DOG_KILL): begin
                    if (q.dog_lock) d.kill = bus_wdata_i;
                end
                ADDR_W'(OFS_IRQ_STATUS):  intr_clr = bus_wdata_i[IRQ_BITS-1:0];
                ADDR_W'(OFS_IRQ_FORCE):   intr_frc = bus_wdata_i[IRQ_BITS-1:0];
                ADDR_W'(OFS_WAKE_REASON): begin
                    if (!bus_wdata_i[0]) d.reason = 1'b0;
                end
                ADDR_W'(OFS_ALERT_FORCE): d.alert = bus_wdata_i[0];
                default: ;
            endcase
        end
        d.intr = (q.intr & ~intr_clr) | intr_frc | intr_hw;
        if (wake_evt) d.reason = 1'b1;
        d.bite = kill_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q          <= '0;
            q.wake_cmp <= '1;
            q.warn     <= '1;
            q.kill     <= '1;
            q.dog_lock <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(OFS_WAKE_CFG):    bus_rdata_o = {{CFG_PAD{1'b0}}, q.presc, q.wake_en};
            ADDR_W'(OFS_WAKE_CNT_LO): bus_rdata_o = wake_cnt[DW-1:0];
            ADDR_W'(OFS_WAKE_CNT_HI): bus_rdata_o = wake_cnt[WAKE_W-1:DW];
            ADDR_W'(OFS_WAKE_CMP_LO): bus_rdata_o = q.wake_cmp[DW-1:0];
            ADDR_W'(OFS_WAKE_CMP_HI): bus_rdata_o = q.wake_cmp[WAKE_W-1:DW];
            ADDR_W'(OFS_DOG_CFG):     bus_rdata_o = {{(DW-2){1'b0}}, q.dog_hold, q.dog_en};
            ADDR_W'(OFS_DOG_LOCK):    bus_rdata_o = {{(DW-1){1'b0}}, q.dog_lock};
            ADDR_W'(OFS_DOG_CNT):     bus_rdata_o = dog_cnt;
            ADDR_W'(OFS_DOG_WARN):    bus_rdata_o = q.warn;
            ADDR_W'(OFS_DOG_KILL):    bus_rdata_o = q.kill;
            ADDR_W'(OFS_IRQ_STATUS):  bus_rdata_o = {{(DW-IRQ_BITS){1'b0}}, q.intr};
            ADDR_W'(OFS_WAKE_REASON): bus_rdata_o = {{(DW-1){1'b0}}, q.reason};
            ADDR_W'(OFS_ALERT_FORCE): bus_rdata_o = {{(DW-1){1'b0}}, q.alert};
            default:                  bus_rdata_o = '0;
        endcase
    end

    assign irq_wake_o = q.intr[IRQ_WAKE_BIT];
    assign wake_req_o = q.intr[IRQ_WAKE_BIT];
    assign irq_bark_o = q.intr[IRQ_BARK_BIT];
    assign nmi_bark_o = q.intr[IRQ_BARK_BIT];
    assign bite_req_o = q.bite;
    assign alert_o    = q.alert;
endmodule

// File: rtl/wwt_chk.sv
module wwt_chk
    import wwt_pkg::*;
#(
    parameter int unsigned DW     = 32,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sleep_i,
    input logic              bus_en_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              wake_en_i,
    input logic [2*DW-1:0]   wake_cnt_i,
    input logic              dog_en_i,
    input logic              dog_hold_i,
    input logic [DW-1:0]     dog_cnt_i,
    input logic              lock_i,
    input logic              irq_wake_o,
    input logic              bite_req_o
);
    logic wr, wake_wr, dog_wr, status_wr;
    assign wr        = bus_en_i && bus_we_i;
    assign wake_wr   = wr && ((bus_addr_i == ADDR_W'(OFS_WAKE_CNT_LO)) ||
                              (bus_addr_i == ADDR_W'(OFS_WAKE_CNT_HI)));
    assign dog_wr    = wr && (bus_addr_i == ADDR_W'(OFS_DOG_CNT));
    assign status_wr = wr && (bus_addr_i == ADDR_W'(OFS_IRQ_STATUS));

    // R9
    lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_i |=> !lock_i);

    // R5
    wake_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wake_en_i && !wake_wr) |=> $stable(wake_cnt_i));

    // R3
    wake_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_en_i && !wake_wr) |=>
        ((wake_cnt_i == $past(wake_cnt_i)) || (wake_cnt_i == $past(wake_cnt_i) + 1'b1)));

    // R6
    dog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dog_hold_i && sleep_i && !dog_wr) |=> $stable(dog_cnt_i));

    // R8
    bite_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bite_req_o |-> $past(dog_en_i));

    // R10
    wake_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_wake_o && !status_wr) |=> irq_wake_o);
endmodule

bind wwt_top wwt_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_i    (sleep_i),
    .bus_en_i   (bus_en_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .wake_en_i  (q.wake_en),
    .wake_cnt_i (wake_cnt),
    .dog_en_i   (q.dog_en),
    .dog_hold_i (q.dog_hold),
    .dog_cnt_i  (dog_cnt),
    .lock_i     (q.dog_lock),
    .irq_wake_o (irq_wake_o),
    .bite_req_o (bite_req_o)
);

// File: tb/tb_wwt_top.sv
module tb_wwt_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_wake, irq_bark, nmi_bark, wake_req, bite_req, alert;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wwt_top dut (
        .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep),
        .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_wake_o(irq_wake), .irq_bark_o(irq_bark), .nmi_bark_o(nmi_bark),
        .wake_req_o(wake_req), .bite_req_o(bite_req), .alert_o(alert)
    );

    // address, write data, expected read-back
    localparam logic [69:0] VEC [7] = '{
        {6'h0C, 32'hA5A5_0001, 32'hA5A5_0001},
        {6'h10, 32'h0000_1234, 32'h0000_1234},
        {6'h00, 32'hFFFF_FFFE, 32'h0000_1FFE},
        {6'h20, 32'h0000_0400, 32'h0000_0400},
        {6'h24, 32'h0000_0800, 32'h0000_0800},
        {6'h08, 32'h0BAD_0000, 32'h0BAD_0000},
        {6'h1C, 32'h0000_0033, 32'h0000_0033}
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sleep = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] a, b, c;
        do_reset();

        // R1 reset state
        rd(6'h18, a); chk("R1 lock", a, 1);
        rd(6'h20, a); chk("R1 warn", a, 32'hFFFF_FFFF);
        rd(6'h10, a); chk("R1 cmp hi", a, 32'hFFFF_FFFF);
        rd(6'h04, a); chk("R1 wake cnt", a, 0);
        rd(6'h1C, a); chk("R1 dog cnt", a, 0);
        chk("R1 outputs", {irq_wake, irq_bark, nmi_bark, wake_req, bite_req, alert}, 0);

        // R2 read-back table
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][69:64], VEC[i][63:32]);
            rd(VEC[i][69:64], a);
            chk("R2 readback", a, {32'h0, VEC[i][31:0]});
        end

        // R3 prescale 3: one step per 4 clocks
        do_reset();
        wr(6'h00, 32'h0000_0007);
        repeat (20) @(negedge clk);
        rd(6'h04, a); chk("R3 prescale count", a, 5);

        // R5 freeze on disable
        wr(6'h00, 32'h0);
        rd(6'h04, a);
        repeat (9) @(negedge clk);
        rd(6'h04, b); chk("R5 frozen count", b, a);

        // R4 full-width compare at 2^32
        do_reset();
        wr(6'h10, 32'h1);
        wr(6'h0C, 32'h0);
        wr(6'h04, 32'hFFFF_FFF0);
        chk("R4 idle while disabled", irq_wake, 0);
        wr(6'h00, 32'h1);
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            if (k == 16) chk("R4 below threshold", irq_wake, 0);
            if (k == 17) chk("R4 at threshold", {irq_wake, wake_req}, 2'b11);
        end
        rd(6'h30, a); chk("R4 reason set", a, 1);
        rd(6'h08, a); chk("R4 count hi", a, 1);

        // R10 W1C after disabling, then force bark
        wr(6'h00, 32'h0);
        wr(6'h30, 32'h0);
        rd(6'h30, a); chk("R4 reason cleared", a, 0);
        chk("R10 wake sticky", irq_wake, 1);
        wr(6'h28, 32'h1);
        chk("R10 w1c wake", irq_wake, 0);
        wr(6'h2C, 32'h2);
        chk("R10 force bark", {irq_bark, nmi_bark}, 2'b11);
        wr(6'h28, 32'h2);
        chk("R10 w1c bark", irq_bark, 0);

        // R5 compare re-evaluated after a count write
        do_reset();
        wr(6'h0C, 32'd100);
        wr(6'h10, 32'd0);
        wr(6'h00, 32'h0000_1FFF);
        wr(6'h04, 32'd100);
        chk("R5 not yet", irq_wake, 0);
        @(negedge clk);
        chk("R5 re-evaluated", irq_wake, 1);

        // R7 / R8 watchdog thresholds
        do_reset();
        wr(6'h20, 32'd10);
        wr(6'h24, 32'd20);
        wr(6'h14, 32'h1);
        for (int k = 1; k <= 21; k++) begin
            @(negedge clk);
            if (k == 10) chk("R7 before warn", irq_bark, 0);
            if (k == 11) chk("R7 bark irq and nmi", {irq_bark, nmi_bark}, 2'b11);
            if (k == 20) chk("R8 before kill", bite_req, 0);
            if (k == 21) chk("R8 bite", bite_req, 1);
        end
        rd(6'h1C, a); chk("R6 counts per clock", a, 21);
        wr(6'h1C, 32'h0);
        @(negedge clk);
        chk("R8 bite drops after clear", bite_req, 0);

        // R6 hold in sleep
        sleep = 1'b1;
        wr(6'h14, 32'h3);
        rd(6'h1C, a);
        repeat (5) @(negedge clk);
        rd(6'h1C, b); chk("R6 held in sleep", b, a);
        sleep = 1'b0;
        repeat (5) @(negedge clk);
        rd(6'h1C, c); chk("R6 resumes", c, b + 5);
        wr(6'h14, 32'h1);
        sleep = 1'b1;
        rd(6'h1C, a);
        repeat (5) @(negedge clk);
        rd(6'h1C, b); chk("R6 sleep ignored", b, a + 5);
        sleep = 1'b0;

        // R9 lock
        wr(6'h18, 32'h0);
        rd(6'h18, a); chk("R9 lock cleared", a, 0);
        wr(6'h20, 32'h55);
        rd(6'h20, a); chk("R9 warn locked", a, 10);
        wr(6'h14, 32'h0);
        rd(6'h14, a); chk("R9 cfg locked", a, 1);
        wr(6'h18, 32'h1);
        rd(6'h18, a); chk("R9 lock stays clear", a, 0);

        // R8 disable drops bite (watchdog unlocked by reset)
        do_reset();
        wr(6'h24, 32'd2);
        wr(6'h14, 32'h1);
        repeat (4) @(negedge clk);
        chk("R8 bite raised", bite_req, 1);
        wr(6'h14, 32'h0);
        @(negedge clk);
        chk("R8 bite drops on disable", bite_req, 0);

        // R11 alert
        wr(6'h34, 32'h1);
        chk("R11 alert on", alert, 1);
        wr(6'h34, 32'h0);
        chk("R11 alert off", alert, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule